// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block controls one private, write-back cache on a snooping bus that keeps copies coherent by update, not by invalidation. Every resident line is in one of four states: exclusive-clean, shared-clean, shared-dirty (this cache wrote it last and memory is stale) or exclusive-dirty. There is no invalid state, so a line that is absent is reached through a miss. When a shared line is written, the new word is broadcast so that peer copies are patched in place.

The processor side takes one read or write at a time. It returns the word, or takes the written bytes, and reports whether the access hit. The bus side issues three commands: a line read, a word update and a line write-back. It also watches the commands of its peers. It drives its share of a wired-OR shared line and supplies a dirty line when a peer reads it. The storage is a direct-mapped array of `NUM_LINES` lines of `LINE_WORDS` words. Memory and the peer caches are outside the block.

Top module: `wupd_cache_ctl`

## Requirements
- R1: After reset no line is present. Every snoop sees `snpShared` low, every access misses (`cpuHit` low), and `busReq` and `cpuReady` are low.
- R2: A read miss issues one line read (`busCmd`=0, `busAddr` with the word-offset bits zero) and returns the granted `busFill` word with `cpuHit` low. The line becomes shared-clean if `busShared` is high at the grant, and exclusive-clean otherwise.
- R3: A write miss issues a line read. If `busShared` is high at that grant, it then issues a word update (`busCmd`=1) and the line ends shared-dirty. Otherwise no further command follows and the line ends exclusive-dirty holding the merged word.
- R4: A write hit on an exclusive-clean or exclusive-dirty line makes no bus request, merges the bytes selected by `cpuBe`, and leaves the line exclusive-dirty.
- R5: A write hit on a shared-clean or shared-dirty line issues a word update. It carries the word address on `busAddr`, the word in bits [DATA_W-1:0] of `busData` and the mask on `busBe`. The line ends shared-dirty if `busShared` is high at the grant, and exclusive-dirty if not. The request stays stable until granted.
- R6: A snooped update (`snpCmd`=1) to a present shared-clean or shared-dirty line merges the bytes selected by `snpBe` into that word and leaves the line shared-clean.
- R7: A snooped line read (`snpCmd`=0) to a present exclusive-dirty or shared-dirty line raises `snpFlush` in the same cycle with the full line on `snpFlushData`, and the line ends shared-dirty.
- R8: A snooped line read to an exclusive-clean line leaves it shared-clean without a flush. A shared-clean line stays shared-clean without a flush.
- R9: A read hit makes no bus request and raises `cpuReady` for one cycle, in the cycle after acceptance, with `cpuHit` high.
- R10: A miss that displaces a dirty line (exclusive-dirty or shared-dirty) first issues a write-back (`busCmd`=2) of that line, at its line-aligned address, and then the line read. A clean victim is dropped without a bus command.
- R11: `snpShared` is high exactly while a valid snoop targets a resident line, whatever its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cpuValid | input | 1 | Processor request, held until `cpuReady` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write word |
| cpuBe | input | DATA_W/8 | Write byte mask |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuHit | output | 1 | Access hit, valid with `cpuReady` |
| cpuRdata | output | DATA_W | Accessed word, valid with `cpuReady` |
| busReq | output | 1 | Bus command pending |
| busCmd | output | 2 | 0 line read, 1 word update, 2 write-back |
| busAddr | output | ADDR_W | Line-aligned address, or word address for an update |
| busData | output | DATA_W*LINE_WORDS | Write-back line, or update word in the low bits |
| busBe | output | DATA_W/8 | Update byte mask (all ones otherwise) |
| busGnt | input | 1 | Command completes at this edge; never together with `snpValid` |
| busShared | input | 1 | Wired-OR shared line, sampled with `busGnt` |
| busFill | input | DATA_W*LINE_WORDS | Line returned for a line read |
| snpValid | input | 1 | Peer command visible on the bus |
| snpCmd | input | 2 | Peer command code, same encoding as `busCmd` |
| snpAddr | input | ADDR_W | Peer word address |
| snpWord | input | DATA_W | Peer update word |
| snpBe | input | DATA_W/8 | Peer update byte mask |
| snpShared | output | 1 | This cache holds the snooped line |
| snpFlush | output | 1 | This cache supplies the dirty line |
| snpFlushData | output | DATA_W*LINE_WORDS | Line being supplied |

## Verification
A read hit is due in the cycle after acceptance. On a miss or a shared write, each bus command completes at the edge where it is granted. The next command, or `cpuReady`, shows in the cycle after the last grant. The snoop outputs are combinational in the cycle the snoop is presented. The state change they cause becomes visible only after that edge. The bench drives and samples on the falling edge. It checks the hit latency, then checks each bus command against its queue at the point where it grants it. It checks the snoop outputs one step after driving them. It tells states apart only through later port behaviour: a silent or broadcast write, and a flush or no flush on a peer read.

// File: rtl/wupd_pkg.sv
package wupd_pkg;

  typedef enum logic [1:0] {
    ST_EXCL    = 2'd0,
    ST_SHCLEAN = 2'd1,
    ST_SHMOD   = 2'd2,
    ST_MOD     = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    CMD_READ   = 2'd0,
    CMD_UPDATE = 2'd1,
    CMD_FLUSH  = 2'd2
  } busCmd_t;

  typedef struct packed {
    logic       fillLine;
    logic       writeWord;
    logic       setState;
    lineState_t nextState;
    logic       dropLine;
  } dpStrobe_t;

  function automatic logic isDirty(input lineState_t s);
    return (s == ST_MOD) || (s == ST_SHMOD);
  endfunction

endpackage

// File: rtl/wupd_dp.sv
module wupd_dp
  import wupd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 4,
  localparam int BE_W      = DATA_W / 8,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W    = DATA_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opWdata,
  input  logic [BE_W-1:0]   opBe,
  input  logic [LINE_W-1:0] busFill,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpWord,
  input  logic [BE_W-1:0]   snpBe,
  output logic              lkHit,
  output logic              lkValid,
  output lineState_t        lkState,
  output logic [TAG_W-1:0]  lkTag,
  output logic [LINE_W-1:0] lkLine,
  output logic              snpShared,
  output logic              snpFlush,
  output logic [LINE_W-1:0] snpFlushData
);

  logic [TAG_W-1:0]  tagArr   [NUM_LINES];
  logic              validArr [NUM_LINES];
  lineState_t        stateArr [NUM_LINES];
  logic [DATA_W-1:0] dataArr  [NUM_LINES][LINE_WORDS];

  logic [IDX_W-1:0]  opIdx, snIdx;
  logic [OFF_W-1:0]  opOff, snOff;
  logic [TAG_W-1:0]  opTag, snTag;
  logic              snHit, snUpdOk;
  logic [DATA_W-1:0] baseWord, newWord, snMerged;

  function automatic logic [DATA_W-1:0] mergeBytes(
    input logic [DATA_W-1:0] oldW,
    input logic [DATA_W-1:0] newW,
    input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    r = oldW;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[b*8 +: 8] = newW[b*8 +: 8];
    return r;
  endfunction

  assign opOff = opAddr[OFF_W-1:0];
  assign opIdx = opAddr[OFF_W +: IDX_W];
  assign opTag = opAddr[ADDR_W-1:OFF_W+IDX_W];
  assign snOff = snpAddr[OFF_W-1:0];
  assign snIdx = snpAddr[OFF_W +: IDX_W];
  assign snTag = snpAddr[ADDR_W-1:OFF_W+IDX_W];

  assign lkValid = validArr[opIdx];
  assign lkState = stateArr[opIdx];
  assign lkTag   = tagArr[opIdx];
  assign lkHit   = validArr[opIdx] && (tagArr[opIdx] == opTag);

  assign snHit     = validArr[snIdx] && (tagArr[snIdx] == snTag);
  assign snpShared = snpValid && snHit;
  assign snpFlush  = snpShared && (snpCmd == CMD_READ) && isDirty(stateArr[snIdx]);
  assign snUpdOk   = snpShared && (snpCmd == CMD_UPDATE) &&
                     ((stateArr[snIdx] == ST_SHCLEAN) || (stateArr[snIdx] == ST_SHMOD));

  generate
    for (genvar gw = 0; gw < LINE_WORDS; gw++) begin : g_lineView
      assign lkLine[gw*DATA_W +: DATA_W]       = dataArr[opIdx][gw];
      assign snpFlushData[gw*DATA_W +: DATA_W] = dataArr[snIdx][gw];
    end
  endgenerate

  assign baseWord = strobe.fillLine ? busFill[opOff*DATA_W +: DATA_W] : dataArr[opIdx][opOff];
  assign newWord  = mergeBytes(baseWord, opWdata, opBe);
  assign snMerged = mergeBytes(dataArr[snIdx][snOff], snpWord, snpBe);

  // storage: tags and data need no reset
  always_ff @(posedge clk) begin
    if (snUpdOk) dataArr[snIdx][snOff] <= snMerged;
    if (strobe.fillLine) begin
      tagArr[opIdx] <= opTag;
      for (int w = 0; w < LINE_WORDS; w++)
        dataArr[opIdx][w] <= busFill[w*DATA_W +: DATA_W];
    end
    if (strobe.writeWord) dataArr[opIdx][opOff] <= newWord;
  end

  // presence and coherence state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        validArr[i] <= 1'b0;
        stateArr[i] <= ST_EXCL;
      end
    end else begin
      if (snpShared && (snpCmd == CMD_READ)) begin
        if (stateArr[snIdx] == ST_EXCL) stateArr[snIdx] <= ST_SHCLEAN;
        if (stateArr[snIdx] == ST_MOD)  stateArr[snIdx] <= ST_SHMOD;
      end
      if (snUpdOk) stateArr[snIdx] <= ST_SHCLEAN;
      if (strobe.setState) stateArr[opIdx] <= strobe.nextState;
      if (strobe.fillLine) validArr[opIdx] <= 1'b1;
      if (strobe.dropLine) validArr[opIdx] <= 1'b0;
    end
  end

endmodule

// File: rtl/wupd_ctrl.sv
module wupd_ctrl
  import wupd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 4,
  localparam int BE_W      = DATA_W / 8,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W    = DATA_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [BE_W-1:0]   cpuBe,
  output logic              cpuReady,
  output logic              cpuHit,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [LINE_W-1:0] busData,
  output logic [BE_W-1:0]   busBe,
  input  logic              busGnt,
  input  logic              busShared,
  input  logic              snpValid,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opWdata,
  output logic [BE_W-1:0]   opBe,
  output dpStrobe_t         strobe,
  input  logic              lkHit,
  input  logic              lkValid,
  input  lineState_t        lkState,
  input  logic [TAG_W-1:0]  lkTag,
  input  logic [LINE_W-1:0] lkLine
);

  typedef enum logic [2:0] {C_IDLE, C_WB, C_FILL, C_UPD, C_RESP} ctlState_t;

  ctlState_t         fsm, fsmNext;
  logic              accept;
  logic              reqWrite, reqHit;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [BE_W-1:0]   reqBe;

  assign opAddr  = (fsm == C_IDLE) ? cpuAddr  : reqAddr;
  assign opWdata = (fsm == C_IDLE) ? cpuWdata : reqWdata;
  assign opBe    = (fsm == C_IDLE) ? cpuBe    : reqBe;

  always_comb begin
    strobe  = '0;
    fsmNext = fsm;
    accept  = 1'b0;
    case (fsm)
      C_IDLE: if (cpuValid && !snpValid) begin
        accept = 1'b1;
        if (lkHit) begin
          if (!cpuWrite) fsmNext = C_RESP;
          else if (lkState == ST_EXCL || lkState == ST_MOD) begin
            strobe.writeWord = 1'b1;
            strobe.setState  = 1'b1;
            strobe.nextState = ST_MOD;
            fsmNext          = C_RESP;
          end else fsmNext = C_UPD;
        end else if (lkValid && isDirty(lkState)) fsmNext = C_WB;
        else fsmNext = C_FILL;
      end
      C_WB: if (busGnt) begin
        strobe.dropLine = 1'b1;
        fsmNext         = C_FILL;
      end
      C_FILL: if (busGnt) begin
        strobe.fillLine = 1'b1;
        strobe.setState = 1'b1;
        if (!reqWrite) begin
          strobe.nextState = busShared ? ST_SHCLEAN : ST_EXCL;
          fsmNext          = C_RESP;
        end else if (busShared) begin
          strobe.nextState = ST_SHCLEAN;
          fsmNext          = C_UPD;
        end else begin
          strobe.writeWord = 1'b1;
          strobe.nextState = ST_MOD;
          fsmNext          = C_RESP;
        end
      end
      C_UPD: if (busGnt) begin
        strobe.writeWord = 1'b1;
        strobe.setState  = 1'b1;
        strobe.nextState = busShared ? ST_SHMOD : ST_MOD;
        fsmNext          = C_RESP;
      end
      C_RESP:  fsmNext = C_IDLE;
      default: fsmNext = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm      <= C_IDLE;
      reqWrite <= 1'b0;
      reqHit   <= 1'b0;
      reqAddr  <= '0;
      reqWdata <= '0;
      reqBe    <= '0;
    end else begin
      fsm <= fsmNext;
      if (accept) begin
        reqWrite <= cpuWrite;
        reqHit   <= lkHit;
        reqAddr  <= cpuAddr;
        reqWdata <= cpuWdata;
        reqBe    <= cpuBe;
      end
    end
  end

  assign busReq = (fsm == C_WB) || (fsm == C_FILL) || (fsm == C_UPD);

  always_comb begin
    busCmd  = CMD_READ;
    busAddr = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    busData = '0;
    busBe   = '1;
    case (fsm)
      C_WB: begin
        busCmd  = CMD_FLUSH;
        busAddr = {lkTag, reqAddr[OFF_W +: IDX_W], {OFF_W{1'b0}}};
        busData = lkLine;
      end
      C_UPD: begin
        busCmd  = CMD_UPDATE;
        busAddr = reqAddr;
        busData = {{(LINE_W-DATA_W){1'b0}}, reqWdata};
        busBe   = reqBe;
      end
      default: ;
    endcase
  end

  assign cpuReady = (fsm == C_RESP);
  assign cpuHit   = (fsm == C_RESP) && reqHit;
  assign cpuRdata = (fsm == C_RESP) ? lkLine[reqAddr[OFF_W-1:0]*DATA_W +: DATA_W] : '0;

endmodule

// File: rtl/wupd_cache_ctl.sv
module wupd_cache_ctl
  import wupd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuValid,
  input  logic                         cpuWrite,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [DATA_W-1:0]            cpuWdata,
  input  logic [DATA_W/8-1:0]          cpuBe,
  output logic                         cpuReady,
  output logic                         cpuHit,
  output logic [DATA_W-1:0]            cpuRdata,
  output logic                         busReq,
  output logic [1:0]                   busCmd,
  output logic [ADDR_W-1:0]            busAddr,
  output logic [DATA_W*LINE_WORDS-1:0] busData,
  output logic [DATA_W/8-1:0]          busBe,
  input  logic                         busGnt,
  input  logic                         busShared,
  input  logic [DATA_W*LINE_WORDS-1:0] busFill,
  input  logic                         snpValid,
  input  logic [1:0]                   snpCmd,
  input  logic [ADDR_W-1:0]            snpAddr,
  input  logic [DATA_W-1:0]            snpWord,
  input  logic [DATA_W/8-1:0]          snpBe,
  output logic                         snpShared,
  output logic                         snpFlush,
  output logic [DATA_W*LINE_WORDS-1:0] snpFlushData
);

  localparam int BE_W   = DATA_W / 8;
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = DATA_W * LINE_WORDS;

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opWdata;
  logic [BE_W-1:0]   opBe;
  logic              lkHit, lkValid;
  lineState_t        lkState;
  logic [TAG_W-1:0]  lkTag;
  logic [LINE_W-1:0] lkLine;

  wupd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuBe(cpuBe),
    .cpuReady(cpuReady), .cpuHit(cpuHit), .cpuRdata(cpuRdata),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busData(busData), .busBe(busBe),
    .busGnt(busGnt), .busShared(busShared), .snpValid(snpValid),
    .opAddr(opAddr), .opWdata(opWdata), .opBe(opBe), .strobe(strobe),
    .lkHit(lkHit), .lkValid(lkValid), .lkState(lkState), .lkTag(lkTag), .lkLine(lkLine)
  );

  wupd_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opAddr(opAddr), .opWdata(opWdata), .opBe(opBe), .busFill(busFill),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr), .snpWord(snpWord), .snpBe(snpBe),
    .lkHit(lkHit), .lkValid(lkValid), .lkState(lkState), .lkTag(lkTag), .lkLine(lkLine),
    .snpShared(snpShared), .snpFlush(snpFlush), .snpFlushData(snpFlushData)
  );

endmodule

// File: rtl/wupd_cache_ctl_chk.sv
module wupd_cache_ctl_chk #(
  parameter int ADDR_W     = 12,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              busReq,
  input logic              busGnt,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic              snpShared,
  input logic              snpFlush
);
  localparam int OFF_W = $clog2(LINE_WORDS);

  a_r9_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  a_r9_no_bus_at_ready: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !busReq);

  a_r7_flush_on_peer_read: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> (snpValid && snpShared && snpCmd == 2'd0));

  a_r11_quiet_without_snoop: assert property (@(posedge clk) disable iff (!rstN)
    !snpValid |-> (!snpShared && !snpFlush));

  a_r5_hold_until_grant: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |=> (busReq && $stable(busCmd) && $stable(busAddr)));

  a_r10_cmd_legal: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busCmd != 2'd3));

  a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busCmd != 2'd1) |-> (busAddr[OFF_W-1:0] == '0));

endmodule

bind wupd_cache_ctl wupd_cache_ctl_chk #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady), .busReq(busReq), .busGnt(busGnt),
  .busCmd(busCmd), .busAddr(busAddr), .snpValid(snpValid), .snpCmd(snpCmd),
  .snpShared(snpShared), .snpFlush(snpFlush)
);

// File: tb/wupd_cache_ctl_bench.sv
`timescale 1ns/100ps
module wupd_cache_ctl_bench;

  logic         clk = 1'b0;
  logic         rstN;
  logic         cpuValid, cpuWrite;
  logic [11:0]  cpuAddr;
  logic [31:0]  cpuWdata;
  logic [3:0]   cpuBe;
  logic         cpuReady, cpuHit;
  logic [31:0]  cpuRdata;
  logic         busReq;
  logic [1:0]   busCmd;
  logic [11:0]  busAddr;
  logic [127:0] busData;
  logic [3:0]   busBe;
  logic         busGnt, busShared;
  logic [127:0] busFill;
  logic         snpValid;
  logic [1:0]   snpCmd;
  logic [11:0]  snpAddr;
  logic [31:0]  snpWord;
  logic [3:0]   snpBe;
  logic         snpShared, snpFlush;
  logic [127:0] snpFlushData;

  always #2.5 clk = ~clk;

  wupd_cache_ctl u_wupd_cache_ctl (.*);

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;

  // reference model: state 0 excl-clean, 1 shared-clean, 2 shared-dirty, 3 excl-dirty
  bit           mValid [4];
  logic [7:0]   mTag   [4];
  int           mState [4];
  logic [127:0] mLine  [4];
  logic [127:0] memArr [logic [11:0]];

  typedef struct packed {
    logic [1:0]   cmd;
    logic [11:0]  addr;
    logic [127:0] data;
    logic [3:0]   be;
  } busExp_t;
  busExp_t expQ[$];

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] memLine(input logic [11:0] la);
    logic [127:0] r;
    if (memArr.exists(la)) return memArr[la];
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = {20'hC0DE0, la | 12'(w)};
    return r;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycleCnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cpuOp(input bit wr, input logic [11:0] a, input logic [31:0] wd, input logic [3:0] be,
                       input bit sh, input int dly, input string req);
    int idx = int'(a[3:2]);
    int off = int'(a[1:0]);
    logic [11:0] la = {a[11:2], 2'b00};
    bit hit = mValid[idx] && (mTag[idx] == a[11:4]);
    logic [31:0] expRd = '0;
    int waitCnt = 0;
    int cyc = 0;
    bit done = 0;
    expQ.delete();
    if (hit) begin
      if (!wr) expRd = mLine[idx][off*32 +: 32];
      else if (mState[idx] == 0 || mState[idx] == 3) begin
        mLine[idx][off*32 +: 32] = merge(mLine[idx][off*32 +: 32], wd, be);
        mState[idx] = 3;
      end else begin
        expQ.push_back('{2'd1, a, {96'b0, wd}, be});
        mLine[idx][off*32 +: 32] = merge(mLine[idx][off*32 +: 32], wd, be);
        mState[idx] = sh ? 2 : 3;
      end
    end else begin
      if (mValid[idx] && mState[idx] >= 2) begin
        expQ.push_back('{2'd2, {mTag[idx], a[3:2], 2'b00}, mLine[idx], 4'hF});
        memArr[{mTag[idx], a[3:2], 2'b00}] = mLine[idx];
      end
      expQ.push_back('{2'd0, la, 128'b0, 4'hF});
      mValid[idx] = 1; mTag[idx] = a[11:4]; mLine[idx] = memLine(la);
      if (!wr) begin
        mState[idx] = sh ? 1 : 0;
        expRd = mLine[idx][off*32 +: 32];
      end else begin
        mLine[idx][off*32 +: 32] = merge(mLine[idx][off*32 +: 32], wd, be);
        if (sh) begin
          expQ.push_back('{2'd1, a, {96'b0, wd}, be});
          mState[idx] = 2;
        end else mState[idx] = 3;
      end
    end
    @(negedge clk);
    cpuValid = 1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd; cpuBe = be;
    while (!done) begin
      @(negedge clk);
      cyc++;
      busGnt = 0;
      if (cyc > 60) begin
        check(req, "completion timeout", 0, 1);
        done = 1;
      end else if (cpuReady) begin
        check(req, "hit flag", cpuHit, hit);
        if (!wr) check(req, "read word", cpuRdata, expRd);
        if (hit && !wr) check(req, "read-hit latency", cyc, 1);
        check(req, "commands left over", expQ.size(), 0);
        cpuValid = 0;
        done = 1;
      end else if (busReq) begin
        if (waitCnt < dly) waitCnt++;
        else if (expQ.size() == 0) begin
          check(req, "unexpected bus command", {busCmd, busAddr}, 0);
          cpuValid = 0;
          done = 1;
        end else begin
          busExp_t e = expQ.pop_front();
          check(req, "bus command", busCmd, e.cmd);
          check(req, "bus address", busAddr, e.addr);
          if (e.cmd == 2'd2) check(req, "write-back line", busData, e.data);
          if (e.cmd == 2'd1) begin
            check(req, "update word", busData, e.data);
            check(req, "update mask", busBe, e.be);
          end
          busGnt = 1; busShared = sh; busFill = memLine(busAddr);
          waitCnt = 0;
        end
      end
    end
  endtask

  task automatic snoopOp(input logic [1:0] cmd, input logic [11:0] a, input logic [31:0] w,
                         input logic [3:0] be, input string req);
    int idx = int'(a[3:2]);
    int off = int'(a[1:0]);
    bit present = mValid[idx] && (mTag[idx] == a[11:4]);
    bit expFlush = present && cmd == 2'd0 && mState[idx] >= 2;
    @(negedge clk);
    snpValid = 1; snpCmd = cmd; snpAddr = a; snpWord = w; snpBe = be;
    #1;
    check(req, "snoop shared", snpShared, present);
    check(req, "snoop flush", snpFlush, expFlush);
    if (expFlush) begin
      check(req, "flushed line", snpFlushData, mLine[idx]);
      memArr[{a[11:2], 2'b00}] = mLine[idx];
    end
    if (present && cmd == 2'd0) mState[idx] = (mState[idx] == 0) ? 1 : (mState[idx] == 3 ? 2 : mState[idx]);
    if (present && cmd == 2'd1 && (mState[idx] == 1 || mState[idx] == 2)) begin
      mLine[idx][off*32 +: 32] = merge(mLine[idx][off*32 +: 32], w, be);
      mState[idx] = 1;
    end
    @(negedge clk);
    snpValid = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mValid[i] = 0; mState[i] = 0; mTag[i] = '0; mLine[i] = '0; end
    rstN = 0; cpuValid = 0; cpuWrite = 0; cpuAddr = '0; cpuWdata = '0; cpuBe = '0;
    busGnt = 0; busShared = 0; busFill = '0;
    snpValid = 0; snpCmd = '0; snpAddr = '0; snpWord = '0; snpBe = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", "busReq after reset", busReq, 0);
    check("R1", "cpuReady after reset", cpuReady, 0);
    snoopOp(2'd0, 12'h040, 0, 0, "R1 R11 empty cache");
    cpuOp(0, 12'h010, 0, 0, 0, 0, "R1 R2 read miss to exclusive");
    cpuOp(0, 12'h011, 0, 0, 0, 0, "R9 read hit");
    cpuOp(1, 12'h012, 32'hAABBCCDD, 4'hF, 0, 0, "R4 silent write on exclusive");
    snoopOp(2'd0, 12'h010, 0, 0, "R7 peer read of dirty line");
    cpuOp(1, 12'h013, 32'h11112222, 4'b1100, 1, 1, "R5 shared write stays shared");
    snoopOp(2'd1, 12'h013, 32'h12345678, 4'b0011, "R6 peer update");
    snoopOp(2'd0, 12'h010, 0, 0, "R8 peer read of shared-clean");
    cpuOp(0, 12'h013, 0, 0, 0, 0, "R6 merged word visible");
    cpuOp(1, 12'h011, 32'h0F0F0F0F, 4'b0101, 0, 0, "R5 shared write goes exclusive");
    cpuOp(0, 12'h054, 0, 0, 1, 2, "R2 read miss to shared");
    cpuOp(1, 12'h098, 32'hDEADBEEF, 4'hF, 1, 1, "R3 write miss shared");
    snoopOp(2'd0, 12'h098, 0, 0, "R3 R7 shared-dirty supplies");
    cpuOp(1, 12'h0A4, 32'h55667788, 4'b1001, 0, 0, "R3 R10 write miss, clean victim");
    cpuOp(0, 12'h110, 0, 0, 0, 0, "R10 dirty victim written back");
    cpuOp(0, 12'h018, 0, 0, 0, 1, "R10 shared-dirty victim written back");
    cpuOp(0, 12'h0CC, 0, 0, 0, 0, "R2 read miss idx3");
    snoopOp(2'd0, 12'h0CD, 0, 0, "R8 R11 peer read of exclusive");
    cpuOp(1, 12'h0CE, 32'h01020304, 4'hF, 0, 0, "R8 line now shared needs update");
    cpuOp(0, 12'h010, 0, 0, 0, 0, "R10 written-back data returns");
    cpuOp(0, 12'h099, 0, 0, 0, 0, "R10 earlier flush returns");
    snoopOp(2'd1, 12'h300, 32'hFFFFFFFF, 4'hF, "R11 absent line ignored");
    cpuOp(0, 12'h0A5, 0, 0, 0, 0, "R3 exclusive-dirty line readable");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule